// File: doc/BRIEF.md
# Erase Sequencer with Blank Check

This block runs one erase request at a time against a word-organised storage array. A request names one of three region kinds (a small parameter region, a sector or the whole array) and an address inside that region. The sequencer can then start the physical erase at once. It can instead first find out whether the erase is needed at all. An input sampled with the request selects which of the two it does.

With the check selected, the sequencer first asks the array, sector by sector, whether the last erase of each sector covered by the region finished successfully. If any sector reports a failure, the erase is started without reading anything. If every sector reports success, the region is read one word per cycle from its lowest address upward. Reading stops at the first word that holds a 0 bit, and the erase starts straight after. If every word reads as all ones, no erase is started and the request completes with a skipped indication.

The array side has three parts. A status lookup is combinational and indexed by sector. A read port returns data one cycle after the read strobe. An erase start pulse is answered by an erase done pulse. The request side has a busy flag and a single-cycle done pulse that carries the skipped flag.

Top module: `blank_erase_seq`

## Requirements
- R1: After reset, busy, done, skipped, rd_en and erase_start are all 0.
- R2: blank_check_en is sampled when the request is accepted. When it is 0, erase_start is pulsed with no status lookup and no read. The request then completes after erase_done, with skipped = 0.
- R3: With the check selected, the sequencer looks up stat_ok for each sector of the region in ascending order. Any sector with stat_ok = 0 leads to an erase with no reads. It is followed by done with skipped = 0.
- R4: When all sectors of the region report stat_ok = 1, the sequencer reads the words of the region in ascending order, one per cycle, from the region base up to base plus region size minus one. It never reads outside the region.
- R5: A read word is programmed when any of its bits is 0. On the first programmed word, reading stops with no further read, and erase_start pulses in the next cycle. After erase_done the request completes with skipped = 0.
- R6: If every word of the region reads as all ones, no erase is started. The request completes with done = 1 and skipped = 1 one cycle after the last read data returns.
- R7: req_kind selects the region: 0 is a parameter region of 2**PARAM_LG words, 1 is a sector of 2**SECTOR_LG words, and 2 is the whole array of 2**AW words. The base is req_addr rounded down to the region size. Kind 3 is not accepted and has no effect.
- R8: busy is 1 from the cycle after acceptance until done. A request arriving while busy is 1 is ignored and does not alter the running request.
- R9: done is a single-cycle pulse, one per accepted request. skipped is 1 only while done is 1.
- R10: erase_start is a single-cycle pulse, with erase_addr equal to the region base and erase_kind equal to the accepted req_kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | Region kind: 0 parameter, 1 sector, 2 whole array |
| req_addr | input | AW | Any word address inside the region |
| blank_check_en | input | 1 | 1 selects checking before erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | Single-cycle completion pulse |
| skipped | output | 1 | With done: region was blank, no erase run |
| stat_idx | output | AW-SECTOR_LG | Sector whose last-erase status is looked up |
| stat_ok | input | 1 | Last erase of sector stat_idx succeeded |
| rd_en | output | 1 | Word read strobe |
| rd_addr | output | AW | Word read address |
| rd_data | input | DW | Read data, one cycle after rd_en |
| erase_start | output | 1 | Physical erase start pulse |
| erase_kind | output | 2 | Region kind of the erase |
| erase_addr | output | AW | Region base of the erase |
| erase_done | input | 1 | Physical erase finished |

## Verification
Most faults in the scan pointer or its last-word flag show at the read port within one cycle of the fault. They appear as a read out of order, an extra read past the region or a missing final read, and each changes the read count the bench checks against a reference count. A fault in the state sequence shows as an erase started for a blank region, a missing erase after a programmed word or a failed sector, or a skipped flag of the wrong value on the done pulse. All of these are visible within a few cycles of the last read. A region base computed wrongly shows both on the first read address and on erase_addr.

// File: rtl/blank_erase_pkg.sv
package blank_erase_pkg;

    typedef enum logic [1:0] {
        EK_PARAM  = 2'd0,
        EK_SECTOR = 2'd1,
        EK_BULK   = 2'd2,
        EK_RSVD   = 2'd3
    } erase_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_ERASE,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/blank_erase_region.sv
module blank_erase_region #(
    parameter int AW        = 10,
    parameter int PARAM_LG  = 4,
    parameter int SECTOR_LG = 6,
    parameter int SIW       = AW - SECTOR_LG
) (
    input  logic [1:0]     kind,
    input  logic [AW-1:0]  addr,
    output logic           ok,
    output logic [AW-1:0]  base,
    output logic [AW-1:0]  last,
    output logic [SIW-1:0] first_sec,
    output logic [SIW-1:0] last_sec
);
    import blank_erase_pkg::*;

    localparam logic [AW-1:0] PMASK = {{(AW-PARAM_LG){1'b0}}, {PARAM_LG{1'b1}}};
    localparam logic [AW-1:0] SMASK = {{(AW-SECTOR_LG){1'b0}}, {SECTOR_LG{1'b1}}};
    localparam logic [AW-1:0] BMASK = {AW{1'b1}};

    logic [AW-1:0] mask;

    always_comb begin
        case (erase_kind_e'(kind))
            EK_PARAM: mask = PMASK;
            EK_BULK:  mask = BMASK;
            default:  mask = SMASK;
        endcase
        ok        = (erase_kind_e'(kind) != EK_RSVD);
        base      = addr & ~mask;
        last      = base | mask;
        first_sec = base[AW-1:SECTOR_LG];
        last_sec  = last[AW-1:SECTOR_LG];
    end

endmodule

// File: rtl/blank_erase_scan.sv
module blank_erase_scan #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] last,
    input  logic          enable,
    input  logic          stop,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          data_valid,
    output logic          data_last
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] last;
        logic          all_issued;
        logic          rv;
        logic          rlast;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d          = q;
        rd_en      = enable && !q.all_issued && !stop;
        d.rv       = rd_en;
        d.rlast    = rd_en && (q.ptr == q.last);
        if (load) begin
            d.ptr        = base;
            d.last       = last;
            d.all_issued = 1'b0;
            d.rv         = 1'b0;
            d.rlast      = 1'b0;
        end else if (rd_en) begin
            d.ptr = q.ptr + 1'b1;
            if (q.ptr == q.last) begin
                d.all_issued = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr    = q.ptr;
    assign data_valid = q.rv;
    assign data_last  = q.rlast;

    // R4: consecutive reads step by one word
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R4: no read once the final word's data is returning
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_last |-> !rd_en);

endmodule

// File: rtl/blank_erase_seq.sv
module blank_erase_seq #(
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int PARAM_LG  = 4,
    parameter int SECTOR_LG = 6,
    localparam int SIW      = AW - SECTOR_LG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_kind,
    input  logic [AW-1:0]  req_addr,
    input  logic           blank_check_en,
    output logic           busy,
    output logic           done,
    output logic           skipped,
    output logic [SIW-1:0] stat_idx,
    input  logic           stat_ok,
    output logic           rd_en,
    output logic [AW-1:0]  rd_addr,
    input  logic [DW-1:0]  rd_data,
    output logic           erase_start,
    output logic [1:0]     erase_kind,
    output logic [AW-1:0]  erase_addr,
    input  logic           erase_done
);
    import blank_erase_pkg::*;

    typedef struct packed {
        seq_state_e     state;
        logic [1:0]     kind;
        logic [AW-1:0]  base;
        logic [SIW-1:0] sec;
        logic [SIW-1:0] last_sec;
        logic           done;
        logic           skipped;
    } regs_t;

    regs_t q, d;

    logic           reg_ok;
    logic [AW-1:0]  reg_base;
    logic [AW-1:0]  reg_last;
    logic [SIW-1:0] reg_first_sec;
    logic [SIW-1:0] reg_last_sec;
    logic           scan_load;
    logic           scan_en;
    logic           data_valid;
    logic           data_last;
    logic           zero_hit;

    blank_erase_region #(
        .AW(AW), .PARAM_LG(PARAM_LG), .SECTOR_LG(SECTOR_LG), .SIW(SIW)
    ) u_region (
        .kind      (req_kind),
        .addr      (req_addr),
        .ok        (reg_ok),
        .base      (reg_base),
        .last      (reg_last),
        .first_sec (reg_first_sec),
        .last_sec  (reg_last_sec)
    );

    blank_erase_scan #(
        .AW(AW)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (scan_load),
        .base       (reg_base),
        .last       (reg_last),
        .enable     (scan_en),
        .stop       (zero_hit),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .data_valid (data_valid),
        .data_last  (data_last)
    );

    assign zero_hit = data_valid && (rd_data != {DW{1'b1}});
    assign scan_en  = (q.state == ST_SCAN);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.skipped = 1'b0;
        scan_load = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid && reg_ok) begin
                    d.kind     = req_kind;
                    d.base     = reg_base;
                    d.sec      = reg_first_sec;
                    d.last_sec = reg_last_sec;
                    scan_load  = 1'b1;
                    d.state    = blank_check_en ? ST_CHECK : ST_ERASE;
                end
            end
            ST_CHECK: begin
                if (!stat_ok) begin
                    d.state = ST_ERASE;
                end else if (q.sec == q.last_sec) begin
                    d.state = ST_SCAN;
                end else begin
                    d.sec = q.sec + 1'b1;
                end
            end
            ST_SCAN: begin
                if (zero_hit) begin
                    d.state = ST_ERASE;
                end else if (data_valid && data_last) begin
                    d.done    = 1'b1;
                    d.skipped = 1'b1;
                    d.state   = ST_IDLE;
                end
            end
            ST_ERASE: begin
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (erase_done) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.state != ST_IDLE);
    assign done        = q.done;
    assign skipped     = q.skipped;
    assign stat_idx    = q.sec;
    assign erase_start = (q.state == ST_ERASE);
    assign erase_kind  = q.kind;
    assign erase_addr  = q.base;

    // R8: the read port is quiet while idle
    p_idle_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en);

    // R5: a programmed word leads to erase start on the next cycle
    p_zero_starts_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && zero_hit) |=> (erase_start && !rd_en));

    // R3: a failed sector leads to erase with no reads
    p_fail_no_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CHECK && !stat_ok) |=> (erase_start && !rd_en));

    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: skipped appears only with done
    p_skip_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> done);

    // R10: erase start lasts one cycle
    p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

endmodule

// File: tb/tb_blank_erase_seq.sv
`timescale 1ns/1ps
module tb_blank_erase_seq;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int PARAM_LG = 4;
    localparam int SECTOR_LG = 6;
    localparam int SIW = AW - SECTOR_LG;
    localparam int WORDS = 1 << AW;
    localparam int NSEC = 1 << SIW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic blank_check_en = 1'b0;
    logic busy, done, skipped;
    logic [SIW-1:0] stat_idx;
    logic stat_ok;
    logic rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '1;
    logic erase_start;
    logic [1:0] erase_kind;
    logic [AW-1:0] erase_addr;
    logic erase_done = 1'b0;

    logic [DW-1:0] mem [WORDS];
    logic sec_ok [NSEC];

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int rd_cnt = 0;
    int order_err = 0;
    int er_cnt = 0;
    int edly = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [AW-1:0] last_er_addr = '0;
    logic [1:0] last_er_kind = '0;

    always #5 clk = ~clk;

    blank_erase_seq #(.AW(AW), .DW(DW), .PARAM_LG(PARAM_LG), .SECTOR_LG(SECTOR_LG)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .blank_check_en(blank_check_en), .busy(busy),
        .done(done), .skipped(skipped), .stat_idx(stat_idx), .stat_ok(stat_ok),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .erase_start(erase_start), .erase_kind(erase_kind),
        .erase_addr(erase_addr), .erase_done(erase_done)
    );

    assign stat_ok = sec_ok[stat_idx];

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    function automatic int region_size(input logic [1:0] k);
        if (k == 2'd0) return 1 << PARAM_LG;
        if (k == 2'd2) return WORDS;
        return 1 << SECTOR_LG;
    endfunction

    function automatic logic [AW-1:0] region_base(input logic [1:0] k, input logic [AW-1:0] a);
        int sz;
        sz = region_size(k);
        return AW'((int'(a) / sz) * sz);
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitors and array model, all on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rd_en) begin
            if (rd_addr != exp_addr) order_err++;
            exp_addr = exp_addr + 1'b1;
            rd_cnt++;
        end
        erase_done = 1'b0;
        if (edly > 0) begin
            edly--;
            if (edly == 0) begin
                int b;
                int s;
                erase_done = 1'b1;
                b = int'(region_base(last_er_kind, last_er_addr));
                s = region_size(last_er_kind);
                for (int i = b; i < b + s; i++) mem[i] = '1;
                for (int i = b >> SECTOR_LG; i <= (b + s - 1) >> SECTOR_LG; i++) sec_ok[i] = 1'b1;
            end
        end
        if (erase_start) begin
            er_cnt++;
            last_er_addr = erase_addr;
            last_er_kind = erase_kind;
            edly = 1 + int'($urandom % 4);
        end
    end

    // prepare region contents: mode 0 random zero, 1 zero at first word,
    // 2 zero at last word, 3 blank; bad_sec >= 0 marks a sector failed
    task automatic prep(input logic [1:0] k, input logic [AW-1:0] a, input int mode, input int bad_sec);
        int b, s, off;
        b = int'(region_base(k, a));
        s = region_size(k);
        for (int i = b; i < b + s; i++) mem[i] = '1;
        off = -1;
        if (mode == 0) off = int'($urandom % s);
        if (mode == 1) off = 0;
        if (mode == 2) off = s - 1;
        if (off >= 0) mem[b + off] = ~(DW'(1) << ($urandom % DW));
        if (bad_sec >= 0) sec_ok[bad_sec] = 1'b0;
    endtask

    task automatic run_req(input logic [1:0] k, input logic [AW-1:0] a, input bit bce, input bit inject);
        int b, s, exp_reads, exp_er, first_zero, wd;
        bit any_bad, exp_skip, got_skip;
        b = int'(region_base(k, a));
        s = region_size(k);
        any_bad = 1'b0;
        for (int i = b >> SECTOR_LG; i <= (b + s - 1) >> SECTOR_LG; i++)
            if (!sec_ok[i]) any_bad = 1'b1;
        first_zero = -1;
        for (int i = 0; i < s; i++)
            if (first_zero < 0 && mem[b + i] != '1) first_zero = i;
        if (!bce || any_bad) begin
            exp_reads = 0; exp_er = 1; exp_skip = 0;
        end else if (first_zero >= 0) begin
            exp_reads = first_zero + 1; exp_er = 1; exp_skip = 0;
        end else begin
            exp_reads = s; exp_er = 0; exp_skip = 1;
        end
        @(negedge clk);
        rd_cnt = 0; order_err = 0; er_cnt = 0;
        exp_addr = AW'(b);
        req_kind = k; req_addr = a; blank_check_en = bce; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (inject) begin
            req_kind = (k == 2'd2) ? 2'd0 : 2'd2;
            req_addr = AW'($urandom);
            blank_check_en = ~bce;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wd = 0;
        while (!done && wd < 3000) begin
            @(negedge clk);
            wd++;
        end
        check(done == 1'b1, "R9 done reached", done, 1);
        got_skip = skipped;
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
        check(busy == 1'b0, "R8 idle after done", busy, 0);
        check(got_skip == exp_skip, bce ? "R6 skipped flag" : "R2 skipped flag", got_skip, exp_skip);
        check(rd_cnt == exp_reads, !bce ? "R2 no reads" : (any_bad ? "R3 no reads" : "R5 read count"), rd_cnt, exp_reads);
        check(order_err == 0, "R4 ascending reads", order_err, 0);
        check(er_cnt == exp_er, exp_skip ? "R6 no erase" : "R3 erase started", er_cnt, exp_er);
        if (exp_er == 1) begin
            check(last_er_addr == AW'(b), "R10 erase_addr base", last_er_addr, b);
            check(last_er_kind == k, "R10 erase_kind", last_er_kind, k);
        end
    endtask

    initial begin
        void'($urandom(32'd20240613));
        for (int i = 0; i < WORDS; i++) mem[i] = '1;
        for (int i = 0; i < NSEC; i++) sec_ok[i] = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && skipped == 0 && rd_en == 0 && erase_start == 0,
              "R1 reset outputs", {busy, done, skipped, rd_en, erase_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && rd_en == 0 && erase_start == 0,
              "R1 idle after reset", {busy, done, rd_en, erase_start}, 0);

        // directed corners
        prep(2'd1, 10'h085, 3, -1); run_req(2'd1, 10'h085, 1'b0, 1'b0);   // R2
        prep(2'd2, 10'h000, 3, NSEC-1); run_req(2'd2, 10'h123, 1'b1, 1'b0); // R3 last sector bad
        prep(2'd0, 10'h2F7, 2, -1); run_req(2'd0, 10'h2F7, 1'b1, 1'b0);   // R5 zero at last word
        prep(2'd1, 10'h3C1, 1, -1); run_req(2'd1, 10'h3C1, 1'b1, 1'b0);   // R5 zero at first word
        prep(2'd2, 10'h000, 3, -1); run_req(2'd2, 10'h3FF, 1'b1, 1'b0);   // R6 whole array blank
        prep(2'd0, 10'h04A, 3, -1); run_req(2'd0, 10'h04A, 1'b1, 1'b1);   // R8 request ignored while busy
        prep(2'd1, 10'h140, 0, -1); run_req(2'd1, 10'h140, 1'b1, 1'b1);   // R7 sector alignment

        // R7: reserved kind 3 is not accepted
        @(negedge clk);
        rd_cnt = 0; er_cnt = 0;
        req_kind = 2'd3; req_addr = 10'h010; blank_check_en = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0, "R7 kind 3 ignored busy", busy, 0);
        repeat (4) @(negedge clk);
        check(rd_cnt == 0 && er_cnt == 0 && done == 0, "R7 kind 3 no activity", rd_cnt + er_cnt, 0);

        // constrained random mix
        for (int t = 0; t < 60; t++) begin
            logic [1:0] k;
            logic [AW-1:0] a;
            int mode, bad, b, s;
            k = ($urandom % 5 == 0) ? 2'd2 : 2'(($urandom % 2));
            a = AW'($urandom);
            mode = int'($urandom % 4);
            b = int'(region_base(k, a));
            s = region_size(k);
            bad = ($urandom % 6 == 0) ? ((b + int'($urandom % s)) >> SECTOR_LG) : -1;
            prep(k, a, mode, bad);
            run_req(k, a, ($urandom % 5) != 0, ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule